// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block lets software reach the management registers of an Ethernet PHY through a small register window. Software loads the value to be written into a data register, then writes a single command word. That word holds a launch bit, the operation, a 5-bit PHY address and a 5-bit register address. Writing the launch bit starts a Clause 22 management frame on MDC/MDIO. The same bit reads back as busy until the frame has gone out.

For a read, the engine releases MDIO at the turnaround and shifts in the 16 bits the PHY returns. At completion it places them in the upper half of the data register. A separate status bit records whether the PHY failed to pull MDIO low during the second turnaround bit, which means the returned data cannot be trusted. MDC is produced by dividing the system clock. The engine drives MDIO only just after a falling MDC edge and samples it on a rising edge.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, the command, data and status registers read zero, MDC is low and MDIO is not driven (`mdio_oe` low).
- R2: Registers sit at these byte offsets: command at 0x3C0, data at 0x3C4, status at 0x3D0. Any other offset reads zero, and writes to it change nothing.
- R3: A command write with bit 20 set, while the engine is idle, starts a frame. Bit 20 then reads 1 until the frame ends. The command fields read back as written: bit 17 is read, bit 16 is write, bits 12:8 are the PHY address and bits 4:0 are the register address. If bit 17 is set the frame is a read, otherwise it is a write.
- R4: A frame lasts 64 MDC cycles, all sent MSB first:
  - 32 ones;
  - start code 01;
  - opcode 10 for a read, 01 for a write;
  - PHY address;
  - register address;
  - turnaround 10 (driven only on writes);
  - 16 data bits.
- R5: MDC has a period of 2*DIV_HALF system clocks with 50% duty cycle. The value on MDIO changes only in the system cycle where MDC falls, and never where MDC rises.
- R6: On a read, `mdio_oe` goes low from the first turnaround bit to the end of the frame. The 16 bits sampled on the rising MDC edges of the data phase appear in data register bits 31:16 when the frame completes.
- R7: Status bit 0 is set to the MDIO level sampled at the second turnaround bit of each read, so 1 means the data is invalid. Write frames and writes to the status register leave it unchanged.
- R8: A command write made while busy is ignored. The frame in progress continues unchanged, and the command fields keep their earlier values.
- R9: Write data is taken from data register bits 15:0 when the frame is launched. Later writes to the data register do not alter a frame already in progress. Bits 31:16 cannot be written by software.
- R10: A command write with bit 20 clear starts nothing and leaves the command fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset, for both reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest cases to reach from the ports happen in the middle of a frame. One is a second command arriving while the engine is busy. Another is a data register rewrite during a write frame. A third is a read where the PHY leaves the second turnaround bit high. To cover them, the bench issues extra register writes part-way through a running frame. Its PHY responder picks the MDIO level for each turnaround and data bit by tracking which frame bit is on the wire, so valid reads and absent-PHY reads can be mixed back to back. A reference model tracks MDC, the output enable and every driven bit cycle by cycle, so a restarted or altered frame shows up on the first wrong bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = 16;
  localparam int FIELD_W   = 5;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN) + 1;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h3C0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 12'h3C4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h3D0;

  localparam int BIT_GO = 20;
  localparam int BIT_RD = 17;
  localparam int BIT_WR = 16;
  localparam int PHY_LSB = 8;

  typedef struct packed {
    logic               rd;
    logic               wr;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regad;
  } mdio_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c, logic [HALF_W-1:0] wd);
    build_frame = {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick      = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    mdc_d = mdc_q;
    if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R5: the rise tick is followed by MDC high
  assert_rise_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> mdc_q);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy_i,
  input  mdio_cmd_t         cmd_cur_i,
  input  logic [HALF_W-1:0] rdata_i,
  input  logic              invalid_i,
  output logic              start_o,
  output mdio_cmd_t         cmd_new_o,
  output logic [HALF_W-1:0] wdata_o
);
  logic [HALF_W-1:0] dlo_q, dlo_d;
  logic              hit_cmd, hit_data;
  logic              unused_wbits;

  assign hit_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign hit_data = bus_wr && (bus_addr == OFS_DATA);
  assign start_o  = hit_cmd && bus_wdata[BIT_GO] && !busy_i;
  assign unused_wbits = ^{bus_wdata[DATA_W-1:BIT_GO+1], bus_wdata[BIT_GO-1:BIT_RD+1]};

  assign cmd_new_o.rd    = bus_wdata[BIT_RD];
  assign cmd_new_o.wr    = bus_wdata[BIT_WR];
  assign cmd_new_o.phy   = bus_wdata[PHY_LSB +: FIELD_W];
  assign cmd_new_o.regad = bus_wdata[FIELD_W-1:0];
  assign wdata_o         = dlo_q;

  always_comb begin
    dlo_d = dlo_q;
    if (hit_data) dlo_d = bus_wdata[HALF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dlo_q <= '0;
    else        dlo_q <= dlo_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CMD: begin
        bus_rdata[BIT_GO]                 = busy_i;
        bus_rdata[BIT_RD]                 = cmd_cur_i.rd;
        bus_rdata[BIT_WR]                 = cmd_cur_i.wr;
        bus_rdata[PHY_LSB +: FIELD_W]     = cmd_cur_i.phy;
        bus_rdata[FIELD_W-1:0]            = cmd_cur_i.regad;
      end
      OFS_DATA: bus_rdata = {rdata_i, dlo_q};
      OFS_STAT: bus_rdata[0] = invalid_i;
      default:  bus_rdata = '0;
    endcase
  end

  // R9: the write-data half changes only through a data-register write
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_data |=> $stable(dlo_q));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy_o,
  output mdio_cmd_t         cmd_o,
  output logic [HALF_W-1:0] rdata_o,
  output logic              invalid_o,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  mdio_cmd_t            cmd_q, cmd_d;
  logic [HALF_W-1:0]    shift_q, shift_d, rdata_q, rdata_d;
  logic                 ta_q, ta_d, inv_q, inv_d, o_q, o_d, oe_q, oe_d;

  always_comb begin
    busy_d  = busy_q;  idx_d  = idx_q;  frame_d = frame_q; cmd_d = cmd_q;
    shift_d = shift_q; rdata_d = rdata_q; ta_d = ta_q; inv_d = inv_q;
    o_d     = o_q;     oe_d   = oe_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        cmd_d   = cmd_i;
        frame_d = build_frame(cmd_i, wdata_i);
      end
    end else if (fall_tick) begin
      if (idx_q == IDX_W'(FRAME_LEN)) begin
        busy_d = 1'b0;
        oe_d   = 1'b0;
        o_d    = 1'b1;
        if (cmd_q.rd) begin
          rdata_d = shift_q;
          inv_d   = ta_q;
        end
      end else begin
        o_d     = frame_q[FRAME_LEN-1];
        frame_d = {frame_q[FRAME_LEN-2:0], 1'b0};
        oe_d    = !(cmd_q.rd && (idx_q >= IDX_W'(TA_POS)));
        idx_d   = idx_q + IDX_W'(1);
      end
    end else if (rise_tick && cmd_q.rd) begin
      if (idx_q == IDX_W'(TA_POS + 2)) ta_d = mdio_i;
      if (idx_q > IDX_W'(DATA_POS))    shift_d = {shift_q[HALF_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; idx_q <= '0; frame_q <= '0; cmd_q <= '0;
      shift_q <= '0; rdata_q <= '0; ta_q <= 1'b0; inv_q <= 1'b0;
      o_q <= 1'b1; oe_q <= 1'b0;
    end else begin
      busy_q <= busy_d; idx_q <= idx_d; frame_q <= frame_d; cmd_q <= cmd_d;
      shift_q <= shift_d; rdata_q <= rdata_d; ta_q <= ta_d; inv_q <= inv_d;
      o_q <= o_d; oe_q <= oe_d;
    end
  end

  assign busy_o    = busy_q;
  assign cmd_o     = cmd_q;
  assign rdata_o   = rdata_q;
  assign invalid_o = inv_q;
  assign mdio_o    = o_q;
  assign mdio_oe   = oe_q;

  // R3: busy rises only on a launch request
  assert_busy_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i));
  // R4: the frame ends on a falling tick after all bits went out
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(fall_tick) && $past(idx_q) == IDX_W'(FRAME_LEN)));
  // R6: the pin is released past the turnaround start of a read
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q.rd && idx_q > IDX_W'(TA_POS)) |-> !oe_q);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic              rise_tick, fall_tick, busy, start, invalid;
  mdio_cmd_t         cmd_new, cmd_cur;
  logic [HALF_W-1:0] wdata, rdata;
  logic              hit_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_i), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy),
    .cmd_cur_i(cmd_cur), .rdata_i(rdata), .invalid_i(invalid),
    .start_o(start), .cmd_new_o(cmd_new), .wdata_o(wdata)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_i), .start_i(start), .cmd_i(cmd_new),
    .wdata_i(wdata), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy_o(busy), .cmd_o(cmd_cur), .rdata_o(rdata),
    .invalid_o(invalid), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign hit_cmd = bus_wr && (bus_addr == OFS_CMD);

  // R5: MDIO holds still across a rising MDC edge
  assert_hold_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mdc) |-> $stable(mdio_o));
  // R8: a command written while busy leaves the latched command alone
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && hit_cmd) |=> $stable(cmd_cur));
endmodule

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tot = 0;
  int bad = 0;
  bit finished = 0;

  mdio_cmd_engine #(.DIV_HALF(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #2 clk = ~clk;

  // reference model state
  int       rel = 0;
  int       m_cnt = 0;
  bit       m_mdc = 0, m_busy = 0, m_rd = 0, m_wr = 0, m_o = 1, m_oe = 0, m_inv = 0, m_ta = 0;
  int       m_idx = 0;
  bit [4:0] m_phy = 0, m_reg = 0;
  bit [63:0] m_frame = 0;
  bit [15:0] m_dlo = 0, m_dhi = 0, m_sh = 0;
  bit        phy_ta2 = 0;
  bit [15:0] phy_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_cnt = 0; m_mdc = 0; m_busy = 0; m_rd = 0; m_wr = 0; m_o = 1; m_oe = 0;
      m_inv = 0; m_ta = 0; m_idx = 0; m_phy = 0; m_reg = 0; m_dlo = 0; m_dhi = 0; m_sh = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        bit tick, rise, fall;
        tick = (m_cnt == D - 1);
        rise = tick && !m_mdc;
        fall = tick && m_mdc;
        if (!m_busy) begin
          if (bus_wr && bus_addr == 12'h3C0 && bus_wdata[20]) begin
            m_busy = 1; m_idx = 0;
            m_rd = bus_wdata[17]; m_wr = bus_wdata[16];
            m_phy = bus_wdata[12:8]; m_reg = bus_wdata[4:0];
            m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), m_phy, m_reg, 2'b10, m_dlo};
          end
        end else if (fall) begin
          if (m_idx == 64) begin
            m_busy = 0; m_oe = 0; m_o = 1;
            if (m_rd) begin m_dhi = m_sh; m_inv = m_ta; end
          end else begin
            m_o = m_frame[63 - m_idx];
            m_oe = !(m_rd && m_idx >= 46);
            m_idx++;
          end
        end else if (rise && m_rd && m_idx > 0) begin
          if (m_idx - 1 == 47) m_ta = mdio_i;
          if (m_idx - 1 >= 48) m_sh = {m_sh[14:0], mdio_i};
        end
        if (bus_wr && bus_addr == 12'h3C4) m_dlo = bus_wdata[15:0];
        if (tick) begin m_cnt = 0; m_mdc = !m_mdc; end
        else m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and PHY responder
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(mdc === m_mdc, "R5 mdc", {31'b0, mdc}, {31'b0, m_mdc});
      chk(mdio_oe === m_oe, "R6 oe", {31'b0, mdio_oe}, {31'b0, m_oe});
      if (m_oe) chk(mdio_o === m_o, "R4 bit", {31'b0, mdio_o}, {31'b0, m_o});
      if (m_busy && m_rd && m_idx >= 48) begin
        if (m_idx - 1 == 47) mdio_i <= phy_ta2;
        else if (m_idx - 1 >= 48) mdio_i <= phy_data[63 - (m_idx - 1)];
        else mdio_i <= 1'b1;
      end else mdio_i <= 1'b1;
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h3C0: model_read = {11'b0, m_busy, 2'b0, m_rd, m_wr, 3'b0, m_phy, 3'b0, m_reg};
      12'h3C4: model_read = {m_dhi, m_dlo};
      12'h3D0: model_read = {31'b0, m_inv};
      default: model_read = 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_model(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata === model_read(a), tag, bus_rdata, model_read(a));
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk((bus_rdata & mask) === exp, tag, bus_rdata & mask, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && m_busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    rd_exp(12'h3C0, 32'hFFFF_FFFF, 32'h0, "R1 cmd reset");
    rd_exp(12'h3C4, 32'hFFFF_FFFF, 32'h0, "R1 data reset");
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h0, "R1 status reset");
    chk(mdio_oe === 1'b0, "R1 oe reset", {31'b0, mdio_oe}, 32'h0);

    // R9 data low half writable, upper half not
    wr(12'h3C4, 32'hBEEF_A5C3);
    rd_exp(12'h3C4, 32'hFFFF_FFFF, 32'h0000_A5C3, "R9 data write");

    // R2 unmapped offset
    wr(12'h3C8, 32'hFFFF_FFFF);
    rd_exp(12'h3C8, 32'hFFFF_FFFF, 32'h0, "R2 unmapped read");
    rd_exp(12'h3C4, 32'hFFFF_FFFF, 32'h0000_A5C3, "R2 unmapped write no effect");
    rd_model(12'h3C0, "R2 cmd unchanged");

    // R10 command without launch bit
    wr(12'h3C0, 32'h0002_0105);
    rd_exp(12'h3C0, 32'hFFFF_FFFF, 32'h0, "R10 no launch");

    // R3 write frame launch
    wr(12'h3C0, 32'h0011_150A);
    rd_exp(12'h3C0, 32'hFFFF_FFFF, 32'h0011_150A, "R3 busy and fields");
    repeat (40) @(negedge clk);
    // R8 command while busy ignored, R9 data rewrite mid-frame
    wr(12'h3C0, 32'h0012_1F1F);
    wr(12'h3C4, 32'h0000_1111);
    rd_exp(12'h3C0, 32'hFFFF_FFFF, 32'h0011_150A, "R8 ignored while busy");
    wait_idle();
    rd_exp(12'h3C0, 32'hFFFF_FFFF, 32'h0001_150A, "R3 busy cleared");
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h0, "R7 write frame leaves status");

    // R6 valid read
    phy_ta2 = 1'b0; phy_data = 16'h1234;
    wr(12'h3C0, 32'h0012_0302);
    wait_idle();
    rd_exp(12'h3C4, 32'hFFFF_0000, 32'h1234_0000, "R6 read data");
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h0, "R7 valid read");

    // R7 absent PHY
    phy_ta2 = 1'b1; phy_data = 16'hFFFF;
    wr(12'h3C0, 32'h0012_1F01);
    wait_idle();
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h1, "R7 invalid flag");
    rd_exp(12'h3C4, 32'hFFFF_0000, 32'hFFFF_0000, "R6 all ones data");
    wr(12'h3D0, 32'h0);
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h1, "R7 status not writable");

    // R6 R7 another valid read clears the flag
    phy_ta2 = 1'b0; phy_data = 16'hC0DE;
    wr(12'h3C0, 32'h0012_0011);
    wait_idle();
    rd_exp(12'h3C4, 32'hFFFF_0000, 32'hC0DE_0000, "R6 second read");
    rd_exp(12'h3D0, 32'hFFFF_FFFF, 32'h0, "R7 flag cleared");
    rd_model(12'h3C4, "R9 data model");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      tot++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end
endmodule